// File: doc/BRIEF.md
# Cascadable Bidirectional Pixel Sampling Chain

This block is the input front end of a display column driver. It waits for a start token on one of two shared cascade pins. Once the token is accepted, it walks an internal stage pointer across the pixel groups of a line register, one group per clock. At each rising edge it stores one pixel, made of three 6-bit colour words, into the active group. Each word can be complemented on the way in to cut bus switching. When the last group has been written, the block drives a one-clock token on the other cascade pin, so the next device in a daisy chain can start sampling.

The direction input picks which pin receives the token and which pin sends it, and also the order in which groups are filled. The channel-count input picks full mode (103 groups, 309 channels) or reduced mode (100 groups). Reduced mode skips the three middle groups that cover channels 151 to 159. The sequencer has three states:

- ST_IDLE waits for a rising edge on the entry pin and then goes to ST_FILL.
- ST_FILL writes one group per clock and moves to ST_EMIT after the last group.
- ST_EMIT drives the output token. It returns to ST_IDLE, or goes straight back to ST_FILL if a new rising edge is seen in that same cycle.

Top module: `casc_pixel_chain`

## Requirements
- R1: With `dir_right`=1 the start token is read from `cas_a` and the output token is driven on `cas_b`. With `dir_right`=0 the roles swap. The pin acting as input is left at high impedance.
- R2: A token is accepted at the first rising clock edge where the entry pin is 1 after having been 0 at the previous edge. No pixel is stored at that edge. At each of the following edges, one pixel is written into the next group. Colour word `col0` goes to word 0, `col1` to word 1 and `col2` to word 2. Group g, word c occupies `line_o[(3g+c)*6 +: 6]`. Groups that are not written keep their contents.
- R3: With `dir_right`=1 the groups are filled from group 0 upward. With `dir_right`=0 they are filled from group 102 downward.
- R4: With `short_mode`=0 the chain has 103 steps. With `short_mode`=1 it has 100 steps and skips groups 50, 51 and 52, which keep their previous contents.
- R5: When `invert`=1 at a capture edge, each stored word is the bitwise complement of its input. For example 0x00 is stored as 0x3F, 0x07 as 0x38 and 0x15 as 0x2A.
- R6: The output token is 1 for exactly one clock cycle: the cycle that follows the edge at which the last group is written. At all other times it is 0.
- R7: A start pulse wider than one clock, or a new rising edge on the entry pin while groups are still being filled, launches no second line and does not disturb the fill.
- R8: A rising edge on the entry pin sampled at the edge that ends the output-token cycle launches a new line at once. Its first pixel is stored at the next edge.
- R9: Synchronous reset `rst`=1 clears the line register, the sequencer and any pending token. An entry pin that is already 1 when reset is released is not taken as a start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dir_right | input | 1 | 1: enter on `cas_a`, fill upward; 0: enter on `cas_b`, fill downward |
| short_mode | input | 1 | 1: 100-group chain skipping groups 50..52; 0: 103 groups |
| invert | input | 1 | 1: store complemented colour words |
| col0 | input | 6 | Colour word for the first channel of a group |
| col1 | input | 6 | Colour word for the second channel of a group |
| col2 | input | 6 | Colour word for the third channel of a group |
| cas_a | inout | 1 | Cascade pin: start input when `dir_right`=1, token output otherwise |
| cas_b | inout | 1 | Cascade pin: token output when `dir_right`=1, start input otherwise |
| line_o | output | 1854 | First-rank line register, group-major, 18 bits per group |

## Verification
The end of one line and the start of the next can fall in the same cycle. The edge that closes the output-token cycle can also be the edge that samples a fresh rising start.

The bench provokes this by chaining lines back to back. It raises the entry pin in exactly the cycle in which it expects the token. It then judges two things: the token was high for one cycle only, and the second line's pixels landed in their groups starting at the very next edge, in the order its direction and mode demand.

Randomised lines with wide start pulses and stray pulses in mid-fill check that overlapping starts never create a second token.

// File: rtl/casc_pkg.sv
package casc_pkg;

    // Sequencer states of the sampling chain
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_EMIT = 2'd2
    } chain_state_t;

    // Colour words captured per pixel group
    localparam int unsigned LANES = 3;

endpackage

// File: rtl/casc_word_cond.sv
module casc_word_cond #(
    parameter int unsigned WORD_W = 6,
    parameter int unsigned LANES  = 3
) (
    input  logic                      invert,
    input  logic [LANES*WORD_W-1:0]   words_in,
    output logic [LANES*WORD_W-1:0]   words_out
);

    // One conditional complement per colour lane
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign words_out[l*WORD_W +: WORD_W] =
            invert ? ~words_in[l*WORD_W +: WORD_W] : words_in[l*WORD_W +: WORD_W];
    end

endmodule

// File: rtl/casc_seq_ctrl.sv
module casc_seq_ctrl
    import casc_pkg::*;
#(
    parameter int unsigned GRP_FULL = 103,
    parameter int unsigned GAP_LO   = 50,
    parameter int unsigned GAP_N    = 3,
    parameter int unsigned PTR_W    = $clog2(GRP_FULL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_lvl,
    input  logic             dir_right,
    input  logic             short_mode,
    output logic             wr_valid,
    output logic [PTR_W-1:0] wr_grp,
    output logic             tok_out
);

    localparam logic [PTR_W-1:0] P_FIRST = '0;
    localparam logic [PTR_W-1:0] P_LAST  = PTR_W'(GRP_FULL - 1);
    localparam logic [PTR_W-1:0] G_LO    = PTR_W'(GAP_LO);
    localparam logic [PTR_W-1:0] G_HI    = PTR_W'(GAP_LO + GAP_N - 1);
    localparam logic [PTR_W-1:0] G_BELOW = PTR_W'(GAP_LO - 1);
    localparam logic [PTR_W-1:0] G_ABOVE = PTR_W'(GAP_LO + GAP_N);

    chain_state_t     state_q, state_n;
    logic [PTR_W-1:0] ptr_q, ptr_n;
    logic [PTR_W-1:0] step_ptr, launch_ptr;
    logic             dir_q, short_q;
    logic             start_prev_q;
    logic             start_rise, at_end, accept;
    logic             tok_q;

    // Edge detect, end-of-line detect and next group in fill order
    always_comb begin
        start_rise = start_lvl & ~start_prev_q;
        launch_ptr = dir_right ? P_FIRST : P_LAST;
        at_end     = dir_q ? (ptr_q == P_LAST) : (ptr_q == P_FIRST);
        if (dir_q) begin
            step_ptr = ptr_q + 1'b1;
            if (short_q && step_ptr == G_LO) begin
                step_ptr = G_ABOVE;
            end
        end else begin
            step_ptr = ptr_q - 1'b1;
            if (short_q && step_ptr == G_HI) begin
                step_ptr = G_BELOW;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        ptr_n   = ptr_q;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_rise) begin
                    state_n = ST_FILL;
                    ptr_n   = launch_ptr;
                    accept  = 1'b1;
                end
            end
            ST_FILL: begin
                if (at_end) begin
                    state_n = ST_EMIT;
                end else begin
                    ptr_n = step_ptr;
                end
            end
            ST_EMIT: begin
                if (start_rise) begin
                    state_n = ST_FILL;
                    ptr_n   = launch_ptr;
                    accept  = 1'b1;
                end else begin
                    state_n = ST_IDLE;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // State register; direction and mode are frozen when a line is accepted
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= ST_IDLE;
            ptr_q        <= '0;
            dir_q        <= 1'b1;
            short_q      <= 1'b1;
            start_prev_q <= 1'b1;
        end else begin
            state_q      <= state_n;
            ptr_q        <= ptr_n;
            start_prev_q <= start_lvl;
            if (accept) begin
                dir_q   <= dir_right;
                short_q <= short_mode;
            end
        end
    end

    // Output register: token for the cycle after the final write
    always_ff @(posedge clk) begin
        if (rst) begin
            tok_q <= 1'b0;
        end else begin
            tok_q <= (state_q == ST_FILL) && at_end;
        end
    end

    assign wr_valid = (state_q == ST_FILL);
    assign wr_grp   = ptr_q;
    assign tok_out  = tok_q;

    AST_TOK_IN_EMIT: assert property (@(posedge clk) disable iff (rst)
        tok_q |-> (state_q == ST_EMIT)); // R6
    AST_TOK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tok_q |=> !tok_q); // R6
    AST_LAUNCH_POINT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && start_rise) |=>
            (state_q == ST_FILL && ptr_q == (dir_q ? P_FIRST : P_LAST))); // R3
    AST_FILL_DEAF: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FILL && !at_end) |=> (state_q == ST_FILL)); // R7
    AST_GAP_SKIPPED: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FILL && short_q) |-> !(ptr_q >= G_LO && ptr_q <= G_HI)); // R4
    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_FILL) |-> (ptr_q <= P_LAST)); // R2
    AST_EMIT_RELAUNCH: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_EMIT && start_rise) |=> (state_q == ST_FILL)); // R8

endmodule

// File: rtl/casc_line_store.sv
module casc_line_store #(
    parameter int unsigned GRP_FULL = 103,
    parameter int unsigned WORD_W   = 6,
    parameter int unsigned LANES    = 3,
    parameter int unsigned PTR_W    = $clog2(GRP_FULL)
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               wr_valid,
    input  logic [PTR_W-1:0]                   wr_grp,
    input  logic [LANES*WORD_W-1:0]            pix_in,
    output logic [GRP_FULL*LANES*WORD_W-1:0]   line_o
);

    localparam int unsigned GRP_BITS = LANES * WORD_W;

    logic [GRP_FULL-1:0] grp_we;

    // One addressed register per pixel group
    for (genvar g = 0; g < GRP_FULL; g++) begin : g_grp
        logic [GRP_BITS-1:0] grp_q;

        assign grp_we[g] = wr_valid && (wr_grp == PTR_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                grp_q <= '0;
            end else if (grp_we[g]) begin
                grp_q <= pix_in;
            end
        end

        assign line_o[g*GRP_BITS +: GRP_BITS] = grp_q;
    end

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !wr_valid |=> $stable(line_o)); // R2

endmodule

// File: rtl/casc_pixel_chain.sv
module casc_pixel_chain
    import casc_pkg::*;
#(
    parameter int unsigned GRP_FULL = 103,
    parameter int unsigned GAP_LO   = 50,
    parameter int unsigned GAP_N    = 3,
    parameter int unsigned WORD_W   = 6
) (
    input  logic                                 clk,
    input  logic                                 rst,
    input  logic                                 dir_right,
    input  logic                                 short_mode,
    input  logic                                 invert,
    input  logic [WORD_W-1:0]                    col0,
    input  logic [WORD_W-1:0]                    col1,
    input  logic [WORD_W-1:0]                    col2,
    inout  wire                                  cas_a,
    inout  wire                                  cas_b,
    output logic [GRP_FULL*LANES*WORD_W-1:0]     line_o
);

    localparam int unsigned PTR_W  = $clog2(GRP_FULL);
    localparam int unsigned PIX_W  = LANES * WORD_W;

    logic             start_lvl;
    logic             tok;
    logic             wr_valid;
    logic [PTR_W-1:0] wr_grp;
    logic [PIX_W-1:0] pix_raw, pix_cond;

    // Entry pin chosen by direction; exit pin driven, entry pin released
    assign start_lvl = dir_right ? cas_a : cas_b;
    assign cas_a     = dir_right ? 1'bz : tok;
    assign cas_b     = dir_right ? tok  : 1'bz;

    assign pix_raw = {col2, col1, col0};

    casc_word_cond #(
        .WORD_W (WORD_W),
        .LANES  (LANES)
    ) u_cond (
        .invert    (invert),
        .words_in  (pix_raw),
        .words_out (pix_cond)
    );

    casc_seq_ctrl #(
        .GRP_FULL (GRP_FULL),
        .GAP_LO   (GAP_LO),
        .GAP_N    (GAP_N),
        .PTR_W    (PTR_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_lvl  (start_lvl),
        .dir_right  (dir_right),
        .short_mode (short_mode),
        .wr_valid   (wr_valid),
        .wr_grp     (wr_grp),
        .tok_out    (tok)
    );

    casc_line_store #(
        .GRP_FULL (GRP_FULL),
        .WORD_W   (WORD_W),
        .LANES    (LANES),
        .PTR_W    (PTR_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_grp   (wr_grp),
        .pix_in   (pix_cond),
        .line_o   (line_o)
    );

endmodule

// File: tb/casc_pixel_chain_tb.sv
module casc_pixel_chain_tb;

    localparam int GRP    = 103;
    localparam int W      = 6;
    localparam int LINE_W = GRP * 3 * W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tb_dir = 1'b1;
    logic              tb_short = 1'b0;
    logic              tb_inv = 1'b0;
    logic              tb_start = 1'b0;
    logic [W-1:0]      tb_c0 = '0, tb_c1 = '0, tb_c2 = '0;
    wire               pin_a, pin_b;
    logic [LINE_W-1:0] line_w;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W-1:0] exp_mem [GRP][3];

    always #2 clk = ~clk;

    assign pin_a = tb_dir ? tb_start : 1'bz;
    assign pin_b = tb_dir ? 1'bz : tb_start;

    casc_pixel_chain u_dut (
        .clk        (clk),
        .rst        (rst),
        .dir_right  (tb_dir),
        .short_mode (tb_short),
        .invert     (tb_inv),
        .col0       (tb_c0),
        .col1       (tb_c1),
        .col2       (tb_c2),
        .cas_a      (pin_a),
        .cas_b      (pin_b),
        .line_o     (line_w)
    );

    function automatic int map_grp(bit dir, bit shrt, int s);
        if (!shrt) return dir ? s : (GRP - 1 - s);
        if (dir) return (s < 50) ? s : (s + 3);
        return (s < 50) ? (GRP - 1 - s) : (99 - s);
    endfunction

    function automatic logic tok_now();
        return tb_dir ? pin_b : pin_a;
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int g = 0; g < GRP; g++)
            for (int c = 0; c < 3; c++)
                exp_mem[g][c] = '0;
    endtask

    task automatic check_line(string req);
        int bad = -1;
        logic [W-1:0] a = '0, e = '0;
        for (int g = 0; g < GRP; g++)
            for (int c = 0; c < 3; c++)
                if (bad < 0 && line_w[(g*3+c)*W +: W] !== exp_mem[g][c]) begin
                    bad = g * 3 + c;
                    a = line_w[(g*3+c)*W +: W];
                    e = exp_mem[g][c];
                end
        chk(bad < 0, req, {26'd0, a}, {26'd0, e});
    endtask

    // Drive one pixel; when modelled, record what the chosen group must hold
    task automatic drive_pix(bit use_model, int step, int pat);
        if (pat == 1) begin
            tb_c0 = 6'h00; tb_c1 = 6'h07; tb_c2 = 6'h15; tb_inv = 1'b1;
        end else begin
            tb_c0 = $urandom() & 6'h3F;
            tb_c1 = $urandom() & 6'h3F;
            tb_c2 = $urandom() & 6'h3F;
            tb_inv = $urandom() & 1;
        end
        if (use_model) begin
            int g = map_grp(tb_dir, tb_short, step);
            exp_mem[g][0] = tb_inv ? ~tb_c0 : tb_c0;
            exp_mem[g][1] = tb_inv ? ~tb_c1 : tb_c1;
            exp_mem[g][2] = tb_inv ? ~tb_c2 : tb_c2;
        end
    endtask

    // Negedge i precedes edge i; edge 0 takes the token, edges 1..n capture
    task automatic run_line(bit dir, bit shrt, int width, int mid, int pat,
                            bit chain, bit first_now, string req);
        int n = shrt ? 100 : 103;
        tb_dir = dir;
        tb_short = shrt;
        for (int i = 0; i <= n + 1; i++) begin
            if (!(i == 0 && first_now)) @(negedge clk);
            if (i > 0)
                chk(tok_now() == (i == n + 1), (i == n + 1) ? "R6" : "R7",
                    {31'd0, tok_now()}, {31'd0, (i == n + 1)});
            if (i == n + 1) begin
                check_line(req);
                if (chain) return;
                tb_start = 1'b0;
                drive_pix(1'b0, 0, 0);
            end else begin
                tb_start = (i < width) || (mid > 0 && (i == mid || i == mid + 1));
                drive_pix(i > 0, i - 1, pat);
            end
        end
        @(negedge clk);
        chk(tok_now() == 1'b0, "R6", {31'd0, tok_now()}, 32'd0);
    endtask

    initial begin
        bit seen;
        void'($urandom(32'd20240));
        clear_model();

        // R9: entry pin held high across reset release is not a start
        tb_dir = 1'b1;
        tb_start = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_line("R9");
        chk(tok_now() == 1'b0, "R9", {31'd0, tok_now()}, 32'd0);
        seen = 1'b0;
        repeat (110) begin
            @(negedge clk);
            seen |= tok_now();
        end
        chk(!seen, "R9", {31'd0, seen}, 32'd0);
        check_line("R9");
        tb_start = 1'b0;
        repeat (2) @(negedge clk);

        // R5: directed complement values in a full upward line
        run_line(1'b1, 1'b0, 1, 0, 1, 1'b0, 1'b0, "R5");
        chk(line_w[5:0] == 6'h3F, "R5", {26'd0, line_w[5:0]}, 32'h3F);
        chk(line_w[11:6] == 6'h38, "R5", {26'd0, line_w[11:6]}, 32'h38);
        chk(line_w[17:12] == 6'h2A, "R5", {26'd0, line_w[17:12]}, 32'h2A);

        // R1/R2: random upward line with a wide start pulse
        run_line(1'b1, 1'b0, 3, 0, 0, 1'b0, 1'b0, "R1");
        // R3: downward line entering on the second pin, stray pulse mid-fill (R7)
        run_line(1'b0, 1'b0, 4, 40, 0, 1'b0, 1'b0, "R3");
        // R4: reduced mode in both directions; groups 50..52 must keep old data
        run_line(1'b1, 1'b1, 2, 0, 0, 1'b0, 1'b0, "R4");
        run_line(1'b0, 1'b1, 5, 60, 0, 1'b0, 1'b0, "R4");

        // R8: new start sampled in the token cycle, both directions
        run_line(1'b0, 1'b1, 2, 0, 0, 1'b1, 1'b0, "R8");
        run_line(1'b0, 1'b1, 1, 0, 0, 1'b0, 1'b1, "R8");
        run_line(1'b1, 1'b0, 2, 0, 0, 1'b1, 1'b0, "R8");
        run_line(1'b1, 1'b0, 3, 0, 0, 1'b0, 1'b1, "R8");

        // R2: constrained random lines
        for (int k = 0; k < 4; k++) begin
            bit d = $urandom() & 1;
            bit s = $urandom() & 1;
            int w = 1 + ($urandom() % 5);
            int m = ($urandom() & 1) ? (30 + ($urandom() % 50)) : 0;
            run_line(d, s, w, m, 0, 1'b0, 1'b0, "R2");
        end

        // R9: reset in the middle of a line drops the line and its token
        @(negedge clk);
        tb_dir = 1'b1;
        tb_short = 1'b0;
        tb_start = 1'b1;
        drive_pix(1'b0, 0, 0);
        repeat (20) begin
            @(negedge clk);
            tb_start = 1'b0;
            drive_pix(1'b0, 0, 0);
        end
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        clear_model();
        seen = 1'b0;
        repeat (110) begin
            @(negedge clk);
            seen |= tok_now();
        end
        chk(!seen, "R9", {31'd0, seen}, 32'd0);
        check_line("R9");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R6 watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule